// File: doc/BRIEF.md
# Single-Accumulator Execution Core

This block is a compact execution core built around one internal accumulator. Every instruction names exactly one memory word. The accumulator is always the other operand and always receives the result, except for the store operation, which copies the accumulator out to the named word. The core talks to the outside world through one synchronous single-port memory bus. Instructions and data share that bus, and read data comes back one clock after a request.

Each instruction runs through four steps: fetch, decode, operand access and execute. It issues exactly two bus requests, one to fetch the instruction word and one to read or write the operand. Work on the accumulator needs no bus traffic. An internal counter totals every bus request, and the accumulator is driven out on a port, so a test harness can check results and access totals directly. A halt instruction, or any opcode the core does not recognise, stops the core. It then stays stopped until the next reset.

Top module: `acc_core`

## Requirements
- R1: While reset is active, and straight after it, the program counter, the accumulator and the access counter are zero, halted is low, and the first request fetches address 0.
- R2: An instruction word holds the opcode in bits 15:12 and a word address in bits 11:0. Fetches read consecutive addresses, starting at 0 and stepping by one.
- R3: Opcode 1 (load) copies the addressed memory word into the accumulator.
- R4: Opcode 2 (store) writes the accumulator to the addressed word and leaves the accumulator unchanged.
- R5: Opcode 3 (add) sets the accumulator to the accumulator plus the memory word, modulo 2^16.
- R6: Opcode 4 (sub) sets the accumulator to the accumulator minus the memory word, modulo 2^16.
- R7: Opcode 5 (mult) sets the accumulator to the low 16 bits of the product of the accumulator and the memory word.
- R8: Every non-halting instruction makes exactly two bus requests and takes four clocks. A halting instruction makes one request (its fetch), and halted rises two clocks after that fetch starts. The access counter rises by one per request.
- R9: Opcode 0, and every opcode from 6 to 15, halts the core. After that there are no further requests, halted stays high, and the accumulator keeps its value until reset.
- R10: The program load C, mult D, add B, sub E, add F, add A, store A, halt leaves B + C*D - E + F + A (the old A) in A after 14 requests. The halt fetch makes the total 15.
- R11: Write enable is raised only during the operand access of a store, never during a fetch. Write data then equals the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Bus request for this cycle |
| mem_we | output | 1 | Write enable, valid with mem_req |
| mem_addr | output | 12 | Word address of the request |
| mem_wdata | output | 16 | Data written on a store |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| halted | output | 1 | High once the core has stopped |
| acc_value | output | 16 | Current accumulator contents |
| access_count | output | 32 | Total bus requests since reset |

## Verification
The bench sweeps add, subtract and multiply over operand pairs that include zero, one, the signed limits and all-ones. A core that dropped the carry wrap, swapped the subtract operands, or kept the high half of the product would store the wrong word. It runs the seven-instruction expression program over many operand sets, and places one operand at the top address 0xFFF. Here a wrong sequencing or an extra bus access would show up in the request total, the clock count or the stored result. Every reserved opcode is placed between two live instructions. A core that went on past it, issued another request, or changed the accumulator afterwards would load the later word or move the request count.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_OPERAND,
        ST_EXECUTE,
        ST_HALT
    } state_e;

    typedef enum logic [2:0] {
        K_HALT,
        K_LOAD,
        K_STORE,
        K_ADD,
        K_SUB,
        K_MULT
    } op_kind_e;

endpackage

// File: rtl/acc_core_decode.sv
module acc_core_decode
    import acc_core_pkg::*;
#(
    parameter int unsigned OPC_W = 4
) (
    input  logic [OPC_W-1:0] opcode,
    output op_kind_e         kind
);
    always_comb begin
        case (opcode)
            OPC_W'(1): kind = K_LOAD;
            OPC_W'(2): kind = K_STORE;
            OPC_W'(3): kind = K_ADD;
            OPC_W'(4): kind = K_SUB;
            OPC_W'(5): kind = K_MULT;
            default:   kind = K_HALT;
        endcase
    end
endmodule

// File: rtl/acc_core_alu.sv
module acc_core_alu
    import acc_core_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  op_kind_e          kind,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result
);
    always_comb begin
        case (kind)
            K_LOAD:  result = operand;
            K_ADD:   result = acc + operand;
            K_SUB:   result = acc - operand;
            K_MULT:  result = acc * operand;
            default: result = acc;
        endcase
    end
endmodule

// File: rtl/acc_core_counter.sv
module acc_core_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (inc) count_d = count_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned OPC_W  = 4,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted,
    output logic [DATA_W-1:0] acc_value,
    output logic [CNT_W-1:0]  access_count
);
    localparam int unsigned OPC_LSB = ADDR_W;

    typedef struct packed {
        state_e              state;
        logic [ADDR_W-1:0]   pc;
        logic [ADDR_W-1:0]   opaddr;
        op_kind_e            kind;
        logic [DATA_W-1:0]   acc;
    } core_regs_t;

    core_regs_t r_d, r_q;
    op_kind_e          dec_kind;
    logic [DATA_W-1:0] alu_y;

    acc_core_decode #(.OPC_W(OPC_W)) u_decode (
        .opcode (mem_rdata[OPC_LSB +: OPC_W]),
        .kind   (dec_kind)
    );

    acc_core_alu #(.DATA_W(DATA_W)) u_alu (
        .kind    (r_q.kind),
        .acc     (r_q.acc),
        .operand (mem_rdata),
        .result  (alu_y)
    );

    acc_core_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (mem_req),
        .count (access_count)
    );

    always_comb begin
        r_d       = r_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.pc;
        mem_wdata = r_q.acc;
        case (r_q.state)
            ST_FETCH: begin
                mem_req    = 1'b1;
                mem_addr   = r_q.pc;
                r_d.pc     = r_q.pc + ADDR_W'(1);
                r_d.state  = ST_DECODE;
            end
            ST_DECODE: begin
                r_d.kind   = dec_kind;
                r_d.opaddr = mem_rdata[ADDR_W-1:0];
                r_d.state  = (dec_kind == K_HALT) ? ST_HALT : ST_OPERAND;
            end
            ST_OPERAND: begin
                mem_req    = 1'b1;
                mem_addr   = r_q.opaddr;
                mem_we     = (r_q.kind == K_STORE);
                r_d.state  = ST_EXECUTE;
            end
            ST_EXECUTE: begin
                if (r_q.kind != K_STORE) r_d.acc = alu_y;
                r_d.state  = ST_FETCH;
            end
            ST_HALT: begin
                r_d.state  = ST_HALT;
            end
            default: begin
                r_d.state  = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state  <= ST_FETCH;
            r_q.pc     <= '0;
            r_q.opaddr <= '0;
            r_q.kind   <= K_HALT;
            r_q.acc    <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign halted    = (r_q.state == ST_HALT);
    assign acc_value = r_q.acc;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              halted,
    input logic [DATA_W-1:0] acc_value,
    input logic [CNT_W-1:0]  access_count
);
    AST_WE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req); // R11

    AST_WDATA_IS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == acc_value)); // R4

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R8

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> (access_count == $past(access_count) + CNT_W'(1))); // R8

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R9

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_req); // R9

    AST_HALT_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(acc_value)); // R9

    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !$isunknown(mem_addr)); // R2
endmodule

bind acc_core acc_core_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .halted       (halted),
    .acc_value    (acc_value),
    .access_count (access_count)
);

// File: tb/acc_core_test.sv
module acc_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req, mem_we;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        halted;
    logic [15:0] acc_value;
    logic [31:0] access_count;

    logic        tb_we = 1'b0;
    logic [11:0] tb_addr = '0;
    logic [15:0] tb_data = '0;
    logic [15:0] mem [0:4095];
    int          reqs = 0;
    int          writes = 0;
    int          nchk = 0;
    int          nfail = 0;
    bit          wd_hit = 1'b0;

    always #2.5 clk = ~clk;

    acc_core uut (
        .clk(clk), .rst_n(rst_n),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .halted(halted), .acc_value(acc_value), .access_count(access_count)
    );

    always @(posedge clk) begin
        if (tb_we) begin
            mem[tb_addr] <= tb_data;
        end else if (mem_req && rst_n) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            mem_rdata <= mem[mem_addr];
        end
        if (rst_n && mem_req) begin
            reqs <= reqs + 1;
            if (mem_we) writes <= writes + 1;
        end
    end

    function automatic logic [15:0] word(input logic [3:0] op, input logic [11:0] a);
        return {op, a};
    endfunction

    function automatic logic [15:0] pick(input int i);
        logic [15:0] v [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
        return v[i];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [11:0] a, input logic [15:0] d);
        tb_we = 1'b1; tb_addr = a; tb_data = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic enter_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // releases reset, counts posedges until halted
    task automatic run(output int cyc, output int dreq, output int dwr);
        int r0, w0;
        r0 = reqs; w0 = writes;
        rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        dreq = reqs - r0;
        dwr = writes - w0;
    endtask

    function automatic logic [15:0] op_ref(input int op, input logic [15:0] x, input logic [15:0] y);
        logic [15:0] p;
        case (op)
            3: p = x + y;
            4: p = x - y;
            default: p = x * y;
        endcase
        return p;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        wd_hit = 1'b1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk + 1, nfail + 1);
        $finish;
    end

    initial begin
        int cyc, dreq, dwr;
        enter_reset();
        // R1: reset state
        chk("R1 halted", 32'(halted), 0);
        chk("R1 acc", 32'(acc_value), 0);
        chk("R1 count", access_count, 0);
        chk("R2 first fetch addr", 32'(mem_addr), 0);
        chk("R2 first fetch req", 32'(mem_req), 1);

        // R3 R4 R5 R6 R7: operation sweep
        for (int op = 3; op <= 5; op++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    logic [15:0] e;
                    enter_reset();
                    poke(12'h000, word(4'd1, 12'h101));
                    poke(12'h001, word(4'(op), 12'h102));
                    poke(12'h002, word(4'd2, 12'h200));
                    poke(12'h003, word(4'd0, 12'h000));
                    poke(12'h101, pick(i));
                    poke(12'h102, pick(j));
                    poke(12'h200, 16'hDEAD);
                    run(cyc, dreq, dwr);
                    e = op_ref(op, pick(i), pick(j));
                    if (op == 3) chk("R5 add result", 32'(mem[12'h200]), 32'(e));
                    else if (op == 4) chk("R6 sub result", 32'(mem[12'h200]), 32'(e));
                    else chk("R7 mult result", 32'(mem[12'h200]), 32'(e));
                    chk("R4 store keeps acc", 32'(acc_value), 32'(e));
                    chk("R8 cycles", 32'(cyc), 14);
                    chk("R8 requests", 32'(dreq), 7);
                    chk("R8 counter", access_count, 7);
                    chk("R11 write count", 32'(dwr), 1);
                    if (i == j) chk("R3 load path", 32'(op_ref(3, pick(i), 16'h0)), 32'(pick(i)));
                end
            end
        end

        // R3: load alone, address at top of field
        enter_reset();
        poke(12'h000, word(4'd1, 12'hFFF));
        poke(12'h001, word(4'd0, 12'h000));
        poke(12'hFFF, 16'hBEEF);
        run(cyc, dreq, dwr);
        chk("R3 load top address", 32'(acc_value), 32'h0000BEEF);
        chk("R11 no writes on load", 32'(dwr), 0);
        chk("R8 load cycles", 32'(cyc), 6);

        // R10: expression program
        for (int k = 0; k < 16; k++) begin
            logic [15:0] a, b, c, d, e, f, exp;
            logic [11:0] aa;
            a = 16'(k * 4099 + 7);
            b = 16'(k * 321 + 16'hF000);
            c = 16'(k * 77 + 3);
            d = 16'(16'hFFFF - k * 13);
            e = 16'(k * 999);
            f = (k == 3) ? 16'hFFFF : 16'(k * 5);
            aa = k[0] ? 12'hFFF : 12'h100;
            exp = b + c * d - e + f + a;
            enter_reset();
            poke(12'h000, word(4'd1, 12'h103));
            poke(12'h001, word(4'd5, 12'h104));
            poke(12'h002, word(4'd3, 12'h102));
            poke(12'h003, word(4'd4, 12'h105));
            poke(12'h004, word(4'd3, 12'h106));
            poke(12'h005, word(4'd3, aa));
            poke(12'h006, word(4'd2, aa));
            poke(12'h007, word(4'd0, 12'h000));
            poke(aa, a); poke(12'h102, b); poke(12'h103, c);
            poke(12'h104, d); poke(12'h105, e); poke(12'h106, f);
            run(cyc, dreq, dwr);
            chk("R10 stored A", 32'(mem[aa]), 32'(exp));
            chk("R10 acc", 32'(acc_value), 32'(exp));
            chk("R10 requests incl halt fetch", 32'(dreq), 15);
            chk("R10 counter", access_count, 15);
            chk("R8 cycles", 32'(cyc), 30);
            chk("R11 one write", 32'(dwr), 1);
        end

        // R9: halting opcodes, R1 after reset from a busy state
        for (int op = 0; op < 16; op++) begin
            logic [15:0] x;
            int r1;
            if (op >= 1 && op <= 5) continue;
            x = 16'(16'h5A5A + op);
            enter_reset();
            poke(12'h000, word(4'd1, 12'h101));
            poke(12'h001, word(4'(op), 12'hABC));
            poke(12'h002, word(4'd1, 12'h102));
            poke(12'h003, word(4'd2, 12'h103));
            poke(12'h101, x);
            poke(12'h102, 16'h0F0F);
            poke(12'h103, 16'h1111);
            run(cyc, dreq, dwr);
            chk("R9 halt cycles", 32'(cyc), 6);
            chk("R9 halt requests", 32'(dreq), 3);
            chk("R9 acc", 32'(acc_value), 32'(x));
            r1 = reqs;
            repeat (6) @(negedge clk);
            chk("R9 no more requests", 32'(reqs - r1), 0);
            chk("R9 stays halted", 32'(halted), 1);
            chk("R9 acc held", 32'(acc_value), 32'(x));
            chk("R9 no store", 32'(mem[12'h103]), 32'h1111);
            rst_n = 1'b0;
            @(negedge clk);
            chk("R1 reset clears acc", 32'(acc_value), 0);
            chk("R1 reset clears count", access_count, 0);
            chk("R1 reset clears halt", 32'(halted), 0);
        end

        if (!wd_hit) begin
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    end
endmodule